// File: doc/BRIEF.md
# Lane-Split Masked Single-Port Memory

This block offers one single-port read/write memory with a per-lane write mask, built from several unmasked single-port sub-arrays of the same depth. The data word is cut into equal lanes. Each lane lives in its own sub-array. Clock, address and access enable go unchanged to every sub-array.

The mask is applied at the edge of each sub-array rather than inside the storage. A sub-array's write-mode input is the global write request ANDed with that lane's mask bit. A lane whose mask bit is clear does a plain read in the same cycle. Read data is the concatenation of the lane outputs, each in its own bit range.

Access is a plain single-cycle request: `cs` marks an access and `we` picks write over read. There is no back-pressure, because every access completes in one cycle. Read data is registered. It appears one cycle after the access and stays put until that lane does another read.

Top module: `masked_lane_mem`

## Requirements
- R1: While `rst_n` is low, and after its release until the first access, `rdata` is all zeros.
- R2: A read (`cs`=1, `we`=0) at an address drives the full stored word on `rdata` after the next rising clock edge. It stays there until a later access makes a lane read.
- R3: A write (`cs`=1, `we`=1) changes only the lanes whose `wmask` bit is 1. Lanes with a 0 mask bit keep their stored contents, and a mask of all zeros leaves the word unchanged.
- R4: During a write, each lane with a 0 mask bit reads the addressed word. After the edge, its `rdata` slice shows that lane's stored value. Slices of lanes with a 1 mask bit keep their previous `rdata` value.
- R5: In a cycle with `cs`=0, `rdata` keeps its value, whatever `we`, `addr`, `wmask` and `wdata` are.
- R6: With `cs`=0, `we`=1 changes no stored word.
- R7: Words at different addresses are independent. A write to one address does not change any other address.
- R8: Lane i holds bits [(i+1)*LANE_W-1 : i*LANE_W] of `wdata` and `rdata`, and `wmask` bit i controls lane i (LANE_W=8, four lanes by default).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by all lanes |
| rst_n | input | 1 | Active-low reset of the read-data registers |
| cs | input | 1 | Access enable |
| we | input | 1 | 1 = write, 0 = read, when `cs` is high |
| addr | input | ADDR_W | Word address, same for all lanes |
| wmask | input | LANES | Per-lane write mask, bit i for lane i |
| wdata | input | DATA_W | Write data, split into lanes |
| rdata | output | DATA_W | Registered read data, joined from the lanes |

## Verification
A lane whose write gating is wrong shows up in the first read of the address it corrupted. That bad lane value appears on `rdata` one cycle after the read. The bench checks reads after partial-mask writes and compares each lane against a word-level model. A lane whose read capture is wrong shows up right after a partial write, because its `rdata` slice must move while the written slices stay fixed. A read register that moves while idle shows up on the next idle cycle.

// File: rtl/lane_split_pkg.sv
package lane_split_pkg;

  typedef enum logic {
    LANE_OP_READ  = 1'b0,
    LANE_OP_WRITE = 1'b1
  } lane_op_e;

  function automatic int lane_total(input int word_w, input int lane_w);
    return word_w / lane_w;
  endfunction

endpackage

// File: rtl/lane_wr_gate.sv
module lane_wr_gate
  import lane_split_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic             we,
  input  logic [LANES-1:0] wmask,
  output lane_op_e         lane_op [LANES]
);

  for (genvar g = 0; g < LANES; g++) begin : g_gate
    always_comb begin
      lane_op[g] = (we && wmask[g]) ? LANE_OP_WRITE : LANE_OP_READ;
    end
  end

endmodule

// File: rtl/lane_sram.sv
module lane_sram
  import lane_split_pkg::*;
#(
  parameter int WIDTH  = 8,
  parameter int DEPTH  = 64,
  parameter int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  lane_op_e          op,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WIDTH-1:0]  wdata,
  output logic [WIDTH-1:0]  rdata
);

  logic [WIDTH-1:0] store [DEPTH];
  logic [WIDTH-1:0] rd_q;

  always_ff @(posedge clk) begin
    if (en && op == LANE_OP_WRITE) begin
      store[addr] <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q <= '0;
    end else if (en && op == LANE_OP_READ) begin
      rd_q <= store[addr];
    end
  end

  assign rdata = rd_q;

endmodule

// File: rtl/masked_lane_mem.sv
module masked_lane_mem
  import lane_split_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int LANE_W = 8,
  parameter int DEPTH  = 64,
  localparam int LANES  = lane_total(DATA_W, LANE_W),
  localparam int ADDR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [LANES-1:0]  wmask,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);

  lane_op_e lane_op [LANES];

  lane_wr_gate #(.LANES(LANES)) gate_i (
    .we      (we),
    .wmask   (wmask),
    .lane_op (lane_op)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    lane_sram #(
      .WIDTH  (LANE_W),
      .DEPTH  (DEPTH),
      .ADDR_W (ADDR_W)
    ) sram_i (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (cs),
      .op    (lane_op[g]),
      .addr  (addr),
      .wdata (wdata[g*LANE_W +: LANE_W]),
      .rdata (rdata[g*LANE_W +: LANE_W])
    );
  end

endmodule

// File: rtl/lane_split_chk.sv
module lane_split_chk #(
  parameter int DATA_W = 32,
  parameter int LANE_W = 8,
  parameter int LANES  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cs,
  input logic              we,
  input logic [LANES-1:0]  wmask,
  input logic [DATA_W-1:0] rdata
);

  // R1: reset clears read data
  p_reset_zero_r1: assert property (@(posedge clk) !rst_n |=> rdata == '0);

  // R5: idle cycle keeps read data
  p_idle_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !cs |=> $stable(rdata));

  // R6: idle write request does not disturb read data
  p_idle_we_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs && we) |=> $stable(rdata));

  // R4: written lanes keep their read slice
  for (genvar g = 0; g < LANES; g++) begin : g_lane_chk
    p_wr_lane_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (cs && we && wmask[g]) |=> $stable(rdata[g*LANE_W +: LANE_W]));
  end

endmodule

bind masked_lane_mem lane_split_chk #(
  .DATA_W (DATA_W),
  .LANE_W (LANE_W),
  .LANES  (LANES)
) chk_i (
  .clk   (clk),
  .rst_n (rst_n),
  .cs    (cs),
  .we    (we),
  .wmask (wmask),
  .rdata (rdata)
);

// File: tb/masked_lane_mem_tb_top.sv
module masked_lane_mem_tb_top;

  localparam int DW    = 32;
  localparam int LW    = 8;
  localparam int DEPTH = 64;
  localparam int LN    = DW / LW;
  localparam int AW    = $clog2(DEPTH);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cs = 1'b0;
  logic          we = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [LN-1:0] wmask = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;

  logic [DW-1:0] model [DEPTH];
  logic [DW-1:0] exp_rd;

  always #4 clk = ~clk;

  masked_lane_mem #(.DATA_W(DW), .LANE_W(LW), .DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst_n(rst_n), .cs(cs), .we(we), .addr(addr),
    .wmask(wmask), .wdata(wdata), .rdata(rdata)
  );

  task automatic check(input string req, input logic [DW-1:0] act,
                       input logic [DW-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] merge(input logic [DW-1:0] old_w,
      input logic [DW-1:0] new_w, input logic [LN-1:0] m);
    logic [DW-1:0] r = old_w;
    for (int i = 0; i < LN; i++)
      if (m[i]) r[i*LW +: LW] = new_w[i*LW +: LW];
    return r;
  endfunction

  // write; lanes with mask clear read the old word (R4)
  task automatic do_write(input logic [AW-1:0] a, input logic [LN-1:0] m,
                          input logic [DW-1:0] d, input string req);
    @(negedge clk);
    cs = 1'b1; we = 1'b1; addr = a; wmask = m; wdata = d;
    @(negedge clk);
    cs = 1'b0; we = 1'b0;
    exp_rd = merge(model[a], exp_rd, m);
    model[a] = merge(model[a], d, m);
    check(req, rdata, exp_rd);
  endtask

  task automatic do_read(input logic [AW-1:0] a, input string req);
    @(negedge clk);
    cs = 1'b1; we = 1'b0; addr = a;
    @(negedge clk);
    cs = 1'b0;
    exp_rd = model[a];
    check(req, rdata, exp_rd);
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 during reset", rdata, '0);
    rst_n = 1'b1;
    @(negedge clk);
    exp_rd = '0;
    check("R1 after release", rdata, '0);
  endtask

  task automatic t_full_words;
    do_write(6'd0,  4'hF, 32'h1122_3344, "R2 full write 0");
    do_write(6'd5,  4'hF, 32'hA5A5_5A5A, "R2 full write 5");
    do_write(6'd63, 4'hF, 32'hDEAD_BEEF, "R2 full write 63");
    do_write(6'd9,  4'hF, 32'h0F0F_F0F0, "R2 full write 9");
    do_read(6'd0,  "R2 read 0");
    do_read(6'd63, "R2 read 63");
    do_read(6'd5,  "R7 read 5");
    do_read(6'd9,  "R7 read 9");
  endtask

  task automatic t_partial;
    do_write(6'd5, 4'b0101, 32'hCCDD_EEFF, "R8 write mask 0101");
    do_read(6'd5, "R3 R8 merged 0101");
    do_write(6'd5, 4'b1000, 32'h7700_0000, "R8 write mask 1000");
    do_read(6'd5, "R8 lane 3 only");
    do_write(6'd5, 4'b0000, 32'hFFFF_FFFF, "R3 write mask 0000");
    do_read(6'd5, "R3 zero mask keeps word");
    do_read(6'd63, "R7 neighbour untouched");
  endtask

  task automatic t_lane_read;
    do_read(6'd9, "R4 prime read");
    do_write(6'd5, 4'b0011, 32'h1357_9BDF, "R4 clear lanes read old word");
    do_write(6'd0, 4'b1110, 32'h2468_ACE0, "R4 lane 0 reads");
    do_read(6'd5, "R3 mask 0011 result");
    do_read(6'd0, "R3 mask 1110 result");
  endtask

  task automatic t_idle;
    do_read(6'd63, "R5 prime read");
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      cs = 1'b0; we = 1'b1; addr = 6'(k * 11); wmask = 4'hF;
      wdata = 32'h5555_0000 + 32'(k);
    end
    @(negedge clk);
    we = 1'b0;
    check("R5 idle rdata held", rdata, exp_rd);
    do_read(6'd0,  "R6 idle write ignored 0");
    do_read(6'd11, "R6 idle write ignored 11");
    do_read(6'd5,  "R6 idle write ignored 5");
  endtask

  initial begin
    for (int i = 0; i < DEPTH; i++) model[i] = '0;
    // Fill addresses touched by idle cycles so the model is exact.
    exp_rd = '0;
    t_reset();
    for (int i = 0; i < DEPTH; i += 11) do_write(6'(i), 4'hF, 32'(i * 3 + 1), "R2 init fill");
    t_full_words();
    t_partial();
    t_lane_read();
    t_idle();
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

endmodule